// File: doc/BRIEF.md
# Serial Peripheral Port with Master and Slave Modes

This block is a full-duplex SPI peripheral that sits behind a small host register interface. When both the enable bit and the master bit are set, a write to the data register starts a transfer. The block generates SCK from a programmable divider, shifts the outgoing word out on MOSI most significant bit first, and samples MISO in the same clocks. When it is enabled but not master, it acts as a slave. An external master selects it by pulling NSS low, and it shifts on the external SCK. In slave mode the SCK, MOSI and NSS inputs pass through two-flop synchronizers.

The frame length is 1 to 8 bits. Received bits land right-aligned in a separate receive buffer, so reads are double buffered. A second completed frame that finds the buffer still unread raises an overrun and is dropped. A data write while a frame is in flight is rejected and raises a collision flag. If NSS is pulled low while the block is master, a mode fault drops the block out of master mode and disables it. All flags are sticky. A completed frame raises a done flag, and that flag drives the interrupt output when interrupts are enabled.

Register map (reg_addr):

- 0: data. A write loads the transmit word. A read returns the receive buffer.
- 1: control. bit0 enable, bit1 master, bit2 interrupt enable, bit4 done, bit5 collision, bit6 overrun, bit7 mode fault.
- 2: configuration. bits[2:0] hold the frame length minus one.
- 3: divider. Each SCK level lasts divider+1 system clocks.

Top module: `spi_port`

## Requirements
- R1: In master mode (control bits 0 and 1 set), a write to address 0 starts a frame of n = cfg[2:0]+1 bits (0 gives 1 bit, 7 gives 8 bits). The low n bits of the written word go out on mosi_o most significant bit first, stable at each SCK rising edge.
- R2: In master mode, miso_i is sampled at each rising edge of sck_o. After the frame, the n received bits are read from address 0 right-aligned, first bit highest, upper bits zero.
- R3: sck_o is low whenever no master frame is running. During a frame each high and low level of sck_o lasts divider+1 system clocks.
- R4: The end of a frame sets control bit4 (done). irq is high exactly while done and control bit2 are both set.
- R5: A write to address 0 during a frame (master frame running, or NSS low in slave mode) sets control bit5 (collision). The word is discarded and the frame's output bits are unchanged.
- R6: If a frame completes while the receive buffer holds unread data, control bit6 (overrun) is set, the new word is dropped and the old word stays readable. Reading address 0 with reg_rd marks the buffer as read.
- R7: In slave mode (bit0 set, bit1 clear), a frame begins when nss_i goes low. mosi_i is captured on the rising edge of sck_i, the loaded word goes out on miso_o most significant bit first, and done is set when nss_i returns high. The received bits are right-aligned at address 0.
- R8: In slave mode, a write to address 0 while nss_i is high loads the next outgoing word. Without such a write, an 8-bit slave frame sends back the word received in the previous frame.
- R9: If nss_i is low while the block is enabled as master, control bit7 (mode fault) is set and control bits 0 and 1 are cleared by hardware.
- R10: Flags in control bits 4 to 7 stay set until the host writes 0 to them. Writing 1 neither sets nor clears them.
- R11: After reset, control, configuration, divider and receive buffer read as 0, and sck_o and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (consumes receive buffer at address 0) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in in master mode |
| sck_i | input | 1 | Serial clock from external master |
| mosi_i | input | 1 | Serial data in in slave mode |
| nss_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data out in slave mode |

## Verification
Several properties are checked on every cycle. A mode fault always demotes the block on the next cycle. A rejected write always leaves the collision flag set. A frame that completes on a full buffer sets overrun and leaves the buffer unchanged. Every completion raises done. SCK stays low outside a master frame, and divider ticks never come back to back when the divider is non-zero. Only the bench's scenarios can show the bit order and alignment of the frame, that each SCK level lasts divider+1 clocks, the slave's resend of the previous word, and that flags cannot be set by software. The bench does this with randomized frame lengths, words and dividers, plus directed collision, overrun, fault and slave cases.

// File: rtl/spi_port_pkg.sv
// Shared constants for the serial peripheral port: data width, length
// field width, register addresses and control bit positions.
package spi_port_pkg;
    localparam int DATA_W = 8;
    localparam int LEN_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_CTRL = 2'd1,
        A_CFG  = 2'd2,
        A_DIV  = 2'd3
    } reg_addr_e;

    localparam int B_EN   = 0;
    localparam int B_MST  = 1;
    localparam int B_IEN  = 2;
    localparam int B_DONE = 4;
    localparam int B_WCOL = 5;
    localparam int B_OVR  = 6;
    localparam int B_MODF = 7;
endpackage

// File: rtl/spi_sync.sv
// Two-flop synchronizer bank for asynchronous serial inputs.
// Assumes each bit is independent; RST_VAL gives the idle level per bit.
module spi_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        // Purpose: two-stage capture of one asynchronous input bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/spi_baud.sv
// Divider for the master serial clock: pulses tick every div+1 cycles
// while run is high. Assumes div is held stable during a frame.
module spi_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Purpose: count system clocks between half-period ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);
endmodule

// File: rtl/spi_shift.sv
// Shared shift register for both modes. A load left-aligns the low n bits
// of the word so the first bit sits at the top; cap stores the incoming bit,
// shift moves it in at bit 0. rx_word is the low n bits, right-aligned.
module spi_shift
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              cap,
    input  logic              cap_bit,
    input  logic              shift,
    output logic              sout,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] sreg;
    logic              rxb;
    logic [LEN_W:0]    lsh;
    logic [DATA_W:0]   top_bit;
    logic [DATA_W:0]   mask;

    assign lsh     = (LEN_W+1)'(DATA_W-1) - {1'b0, len_m1};
    assign top_bit = {{DATA_W{1'b0}}, 1'b1} << ({1'b0, len_m1} + {{LEN_W{1'b0}}, 1'b1});
    assign mask    = top_bit - {{DATA_W{1'b0}}, 1'b1};
    assign sout    = sreg[DATA_W-1];
    assign rx_word = sreg & mask[DATA_W-1:0];

    // Purpose: load, capture and shift the serial word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            rxb  <= 1'b0;
        end else begin
            if (load)       sreg <= load_val << lsh;
            else if (shift) sreg <= {sreg[DATA_W-2:0], rxb};
            if (cap)        rxb  <= cap_bit;
        end
    end
endmodule

// File: rtl/spi_port.sv
// Serial peripheral port top: host registers, master sequencer, slave
// edge detection, receive buffer and sticky flags. Assumes one register
// access per cycle and a synchronous host.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       sck_o,
    output logic       mosi_o,
    input  logic       miso_i,
    input  logic       sck_i,
    input  logic       mosi_i,
    input  logic       nss_i,
    output logic       miso_o
);
    logic en, mst, ien, done, wcol, ovr, modf;
    logic [LEN_W-1:0]  len_m1;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] rx_buf, rx_word;
    logic rx_full, m_busy, sck_r, s_act, fin, sck_q;
    logic [LEN_W-1:0] bitcnt;
    logic sck_s, mosi_s, nss_s, m_tick, sout;
    logic [7:0] ctrl_rd;

    logic data_wr, data_rd, ctrl_wr, fault, s_mode, s_sel, xfer_busy;
    logic load, m_last, s_rise, s_fall, s_end, cap, shift;

    spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({nss_i, mosi_i, sck_i}), .q({nss_s, mosi_s, sck_s})
    );

    spi_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(m_busy), .div(div), .tick(m_tick)
    );

    spi_shift u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(reg_wdata),
        .len_m1(len_m1), .cap(cap), .cap_bit(mst ? miso_i : mosi_s),
        .shift(shift), .sout(sout), .rx_word(rx_word)
    );

    assign data_wr   = reg_wr && (reg_addr == A_DATA);
    assign data_rd   = reg_rd && (reg_addr == A_DATA);
    assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
    assign fault     = en && mst && !nss_s;
    assign s_mode    = en && !mst;
    assign s_sel     = s_mode && !nss_s;
    assign xfer_busy = m_busy || s_act || s_sel;
    assign load      = data_wr && !xfer_busy && !fault;
    assign m_last    = m_busy && m_tick && sck_r && (bitcnt == len_m1);
    assign s_rise    = s_sel && sck_s && !sck_q;
    assign s_fall    = s_sel && !sck_s && sck_q;
    assign s_end     = s_act && nss_s;
    assign cap       = (m_busy && m_tick && !sck_r) || s_rise;
    assign shift     = (m_busy && m_tick && sck_r) || s_fall;

    assign sck_o  = sck_r;
    assign mosi_o = sout;
    assign miso_o = sout;
    assign irq    = done && ien;

    // Purpose: master frame sequencing, SCK level and bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            sck_r  <= 1'b0;
            bitcnt <= '0;
        end else begin
            if (fault || !en || !mst || m_last) m_busy <= 1'b0;
            else if (load)                      m_busy <= 1'b1;
            if (fault || !en || !mst || !m_busy) sck_r <= 1'b0;
            else if (m_tick)                     sck_r <= ~sck_r;
            if (!m_busy)                bitcnt <= '0;
            else if (m_tick && sck_r)   bitcnt <= bitcnt + 1'b1;
        end
    end

    // Purpose: slave selection tracking, SCK edge history, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_act <= 1'b0;
            sck_q <= 1'b0;
            fin   <= 1'b0;
        end else begin
            s_act <= s_sel;
            sck_q <= sck_s;
            fin   <= m_last || s_end;
        end
    end

    // Purpose: control, configuration and divider registers with sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {en, mst, ien, done, wcol, ovr, modf} <= '0;
            len_m1 <= '0;
            div    <= '0;
        end else begin
            if (ctrl_wr) begin
                en   <= reg_wdata[B_EN];
                mst  <= reg_wdata[B_MST];
                ien  <= reg_wdata[B_IEN];
                done <= done & reg_wdata[B_DONE];
                wcol <= wcol & reg_wdata[B_WCOL];
                ovr  <= ovr  & reg_wdata[B_OVR];
                modf <= modf & reg_wdata[B_MODF];
            end
            if (reg_wr && reg_addr == A_CFG) len_m1 <= reg_wdata[LEN_W-1:0];
            if (reg_wr && reg_addr == A_DIV) div    <= DIV_W'(reg_wdata);
            if (fin)                   done <= 1'b1;
            if (fin && rx_full)        ovr  <= 1'b1;
            if (data_wr && xfer_busy)  wcol <= 1'b1;
            if (fault) begin
                modf <= 1'b1;
                en   <= 1'b0;
                mst  <= 1'b0;
            end
        end
    end

    // Purpose: receive buffer with overrun protection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else if (fin && !rx_full) begin
            rx_buf  <= rx_word;
            rx_full <= 1'b1;
        end else if (data_rd) begin
            rx_full <= 1'b0;
        end
    end

    // Purpose: assemble the control read value.
    always_comb begin
        ctrl_rd         = '0;
        ctrl_rd[B_EN]   = en;
        ctrl_rd[B_MST]  = mst;
        ctrl_rd[B_IEN]  = ien;
        ctrl_rd[B_DONE] = done;
        ctrl_rd[B_WCOL] = wcol;
        ctrl_rd[B_OVR]  = ovr;
        ctrl_rd[B_MODF] = modf;
    end

    // Purpose: register read multiplexer.
    always_comb begin
        case (reg_addr)
            A_DATA:  reg_rdata = 8'(rx_buf);
            A_CTRL:  reg_rdata = ctrl_rd;
            A_CFG:   reg_rdata = 8'(len_m1);
            default: reg_rdata = 8'(div);
        endcase
    end

    a_r9_fault_demotes: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (modf && !en && !mst));
    a_r5_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && xfer_busy) |=> wcol);
    a_r6_ovr_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && rx_full) |=> (ovr && $stable(rx_buf)));
    a_r4_done_on_fin: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done);
    a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !m_busy |-> !sck_o);
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic irq, sck_o, mosi_o, miso_o;
    logic miso_i;
    logic sck_i = 1'b0, mosi_i = 1'b0, nss_i = 1'b1;

    int total = 0;
    int bad = 0;

    logic [7:0] sl_val = 8'd0;
    int sl_n = 1;
    int sl_k = 0;
    logic [7:0] mosi_cap = 8'd0;
    time t_rise = 0;
    int hi_cyc = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_port u_spi_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .sck_i(sck_i), .mosi_i(mosi_i), .nss_i(nss_i), .miso_o(miso_o)
    );

    // behavioural slave attached to the master-side pins
    always @* miso_i = (sl_k < sl_n) ? sl_val[sl_n-1-sl_k] : 1'b0;
    always @(posedge sck_o) begin
        mosi_cap = {mosi_cap[6:0], mosi_o};
        t_rise = $time;
    end
    always @(negedge sck_o) begin
        sl_k = sl_k + 1;
        hi_cyc = int'(($time - t_rise) / CLK_P);
    end

    function automatic logic [7:0] fmask(input int n);
        return 8'((9'h1 << n) - 9'h1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            reg_addr = 2'd1;
            #1;
            if (reg_rdata[4]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic master_xfer(input int len_m1, input logic [7:0] tx, input logic [7:0] sv);
        sl_val = sv; sl_n = len_m1 + 1; sl_k = 0; mosi_cap = 8'd0;
        wr(2'd2, 8'(len_m1));
        wr(2'd0, tx);
        wait_done();
    endtask

    task automatic slave_frame(input int n, input logic [7:0] mv, output logic [7:0] got);
        got = 8'd0;
        @(negedge clk); nss_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            mosi_i = mv[n-1-k];
            repeat (8) @(negedge clk);
            got = {got[6:0], miso_o};
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        nss_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d, d2, got;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        reg_addr = 2'd1; #1 chk("R11 ctrl", reg_rdata, 8'h00);
        reg_addr = 2'd0; #1 chk("R11 data", reg_rdata, 8'h00);
        reg_addr = 2'd2; #1 chk("R11 cfg", reg_rdata, 8'h00);
        reg_addr = 2'd3; #1 chk("R11 div", reg_rdata, 8'h00);
        chk("R11 sck", sck_o, 0);
        chk("R11 irq", irq, 0);

        // R1 R2 R3 R4 directed 8-bit master frame
        wr(2'd3, 8'd3);
        wr(2'd1, 8'h07);
        chk("R3 idle sck", sck_o, 0);
        master_xfer(7, 8'hA5, 8'h3C);
        chk("R1 mosi bits", mosi_cap, 8'hA5);
        chk("R3 high level cycles", hi_cyc, 4);
        rd(2'd1, d);
        chk("R4 done", d[4], 1);
        chk("R4 irq set", irq, 1);
        rd(2'd0, d);
        chk("R2 rx 8-bit", d, 8'h3C);
        wr(2'd1, 8'h07);
        chk("R4 irq cleared", irq, 0);
        rd(2'd1, d);
        chk("R10 done cleared", d[4], 0);

        // R1 R2 1-bit frame
        master_xfer(0, 8'hFF, 8'h01);
        chk("R1 mosi 1-bit", mosi_cap, 8'h01);
        rd(2'd0, d);
        chk("R2 rx 1-bit", d, 8'h01);
        wr(2'd1, 8'h07);

        // R1 R2 R3 random frames
        for (int it = 0; it < 20; it++) begin
            int ln, dv;
            logic [7:0] tx, sv;
            ln = int'($urandom % 8); dv = int'($urandom % 4);
            tx = 8'($urandom); sv = 8'($urandom);
            wr(2'd3, 8'(dv));
            master_xfer(ln, tx, sv);
            chk("R1 rand mosi", mosi_cap & fmask(ln + 1), tx & fmask(ln + 1));
            chk("R3 rand level", hi_cyc, dv + 1);
            rd(2'd0, d);
            chk("R2 rand rx", d, sv & fmask(ln + 1));
            wr(2'd1, 8'h07);
        end

        // R5 write collision in master mode
        wr(2'd3, 8'd7);
        sl_val = 8'h55; sl_n = 8; sl_k = 0; mosi_cap = 8'd0;
        wr(2'd2, 8'd7);
        wr(2'd0, 8'hC3);
        repeat (10) @(negedge clk);
        wr(2'd0, 8'h18);
        wait_done();
        chk("R5 frame unchanged", mosi_cap, 8'hC3);
        rd(2'd1, d);
        chk("R5 wcol flag", d[5], 1);
        rd(2'd0, d);
        chk("R5 rx still valid", d, 8'h55);
        wr(2'd1, 8'hF7);
        rd(2'd1, d);
        chk("R10 write one keeps", d[5], 1);
        wr(2'd1, 8'h07);
        rd(2'd1, d);
        chk("R10 write zero clears", d[7:4], 0);

        // R6 overrun
        wr(2'd3, 8'd1);
        master_xfer(7, 8'h11, 8'h9A);
        wr(2'd1, 8'h07);
        master_xfer(7, 8'h22, 8'h46);
        rd(2'd1, d);
        chk("R6 ovr flag", d[6], 1);
        rd(2'd0, d);
        chk("R6 old word kept", d, 8'h9A);
        wr(2'd1, 8'h07);
        master_xfer(7, 8'h33, 8'h77);
        rd(2'd0, d);
        chk("R6 consumed then new", d, 8'h77);
        wr(2'd1, 8'h07);
        rd(2'd1, d);
        chk("R10 flags never set by write", d[7:4], 0);

        // R9 mode fault
        @(negedge clk); nss_i = 1'b0;
        repeat (6) @(negedge clk);
        nss_i = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd1, d);
        chk("R9 modf", d[7], 1);
        chk("R9 en mst cleared", d[1:0], 0);
        chk("R9 sck idle", sck_o, 0);

        // R7 R8 slave mode
        wr(2'd1, 8'h05);
        wr(2'd2, 8'd7);
        wr(2'd0, 8'hB2);
        slave_frame(8, 8'h6D, got);
        chk("R7 slave miso", got, 8'hB2);
        rd(2'd1, d);
        chk("R7 done", d[4], 1);
        chk("R7 irq", irq, 1);
        rd(2'd0, d);
        chk("R7 slave rx", d, 8'h6D);
        wr(2'd1, 8'h05);
        slave_frame(8, 8'h81, got);
        chk("R8 resend previous", got, 8'h6D);
        rd(2'd0, d);
        chk("R8 rx second", d, 8'h81);
        wr(2'd1, 8'h05);

        // R5 slave write while selected, R7 short frame
        wr(2'd2, 8'd3);
        wr(2'd0, 8'h0A);
        @(negedge clk); nss_i = 1'b0;
        repeat (6) @(negedge clk);
        wr(2'd0, 8'h05);
        nss_i = 1'b1;
        repeat (8) @(negedge clk);
        rd(2'd1, d2);
        chk("R5 slave wcol", d2[5], 1);
        rd(2'd0, d);
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h0A);
        slave_frame(4, 8'h0C, got);
        chk("R7 slave 4-bit miso", got, 8'h0A);
        rd(2'd0, d);
        chk("R7 slave 4-bit rx", d, 8'h0C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule